// File: doc/BRIEF.md
# Chained Smart Pixel Receiver Node

This block is one node of a daisy-chained colour pixel string driven by a single data wire. A bit is carried in the width of each high pulse on the input. The node samples the line a fixed time after each rising edge: a long pulse reads as one and a short pulse reads as zero. The node keeps the first 24 bits it decodes after an idle gap. These bits are one byte for each of three colour channels. The node rebuilds every later bit as a clean pulse on its output, so the next node in the chain gets a fresh signal.

When the input has been low for the idle threshold, the node commits its captured word into three 8-bit duty registers. Each register drives its own PWM output. Every node sees the data stop at the same moment, so the whole string changes colour together. If the word is incomplete when the gap arrives, it is dropped. All timing is set in clock cycles through parameters.

Top module: `pix_node`

## Requirements
- R1: A bit is decoded SAMPLE_CYC cycles after a synchronised rising edge of `din`. A high level at that point gives one and a low level gives zero, whatever the exact pulse width is on either side of that point.
- R2: The first 24 bits decoded after an idle gap are captured MSB first. The first byte goes to `duty_dbg[23:16]` and `pwm_o[0]`, the second to `duty_dbg[15:8]` and `pwm_o[1]`, and the third to `duty_dbg[7:0]` and `pwm_o[2]`.
- R3: Every bit decoded after the 24th is sent out on `dout` as a single high pulse. A one is T1H_CYC cycles wide and a zero is T0H_CYC cycles wide, in the same order as received.
- R4: `dout` gives no pulse for any of the first 24 bits of a frame.
- R5: When `din` has stayed low for RESET_CYC cycles and all 24 bits were captured, the captured word is loaded into the duty registers. Capture then starts again from bit zero.
- R6: A frame shorter than 24 bits at the idle gap is discarded. The duty registers keep their values, and the next frame is captured from its own first bit.
- R7: The duty registers change only at an idle-gap commit.
- R8: A channel with duty 0 never drives its PWM output high.
- R9: A channel with duty d is high for exactly d cycles of every 256. Duty 255 therefore gives 255 high cycles out of 256.
- R10: After synchronous reset, all duties are 0, `dout` is low and all PWM outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial pulse-width data in |
| dout | output | 1 | Regenerated serial data to the next node |
| pwm_o | output | 3 | PWM output per colour channel |
| duty_dbg | output | 24 | Current duty registers, channel 0 in the top byte |

## Verification
The RTL assertions check on every cycle the following properties:
- at most one decode happens per rising edge;
- a forward start raises `dout` on the next cycle;
- an idle pulse only fires after the line has been low;
- the duty registers never move without a commit;
- a zero-duty channel stays low.

Only the bench scenarios can show the rest:
- the real word contents and their byte order;
- the widths and order of the regenerated pulses;
- that a partial frame is dropped;
- the exact high count of each PWM output over a 256-cycle window.

// File: rtl/pix_pkg.sv
package pix_pkg;
    localparam int PIX_DW  = 8;
    localparam int PIX_NCH = 3;
    localparam int PIX_FRAME_BITS = PIX_DW * PIX_NCH;

    typedef logic [PIX_NCH-1:0][PIX_DW-1:0] pix_word_t;

    typedef enum logic {ENC_IDLE, ENC_HIGH} enc_state_e;

    typedef struct packed {
        logic vld;
        logic val;
    } pix_bit_t;

    function automatic int unsigned pulse_width(input logic val,
                                                input int unsigned w0,
                                                input int unsigned w1);
        return val ? w1 : w0;
    endfunction
endpackage

// File: rtl/pix_bit_decoder.sv
module pix_bit_decoder
    import pix_pkg::*;
#(
    parameter int SAMPLE_CYC = 150,
    parameter int RESET_CYC  = 70000
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     din,
    output pix_bit_t bit_o,
    output logic     idle_o
);
    localparam int SW = $clog2(SAMPLE_CYC + 1);
    localparam int LW = $clog2(RESET_CYC + 1);

    logic          din_m, din_s, din_p;
    logic          armed;
    logic [SW-1:0] smp_cnt;
    logic [LW-1:0] lo_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            din_m <= 1'b0;
            din_s <= 1'b0;
            din_p <= 1'b0;
        end else begin
            din_m <= din;
            din_s <= din_m;
            din_p <= din_s;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            smp_cnt <= '0;
            bit_o   <= '0;
        end else begin
            bit_o.vld <= 1'b0;
            if (din_s && !din_p) begin
                armed   <= 1'b1;
                smp_cnt <= SW'(1);
            end else if (armed) begin
                if (smp_cnt == SW'(SAMPLE_CYC)) begin
                    bit_o.vld <= 1'b1;
                    bit_o.val <= din_s;
                    armed     <= 1'b0;
                end else begin
                    smp_cnt <= smp_cnt + SW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_cnt <= '0;
            idle_o <= 1'b0;
        end else begin
            idle_o <= !din_s && (lo_cnt == LW'(RESET_CYC - 1));
            if (din_s)
                lo_cnt <= '0;
            else if (lo_cnt != LW'(RESET_CYC))
                lo_cnt <= lo_cnt + LW'(1);
        end
    end

    a_r1_single_sample: assert property (@(posedge clk) disable iff (rst)
        bit_o.vld |=> !bit_o.vld);
    a_r5_idle_needs_low: assert property (@(posedge clk) disable iff (rst)
        idle_o |-> !din_p);
endmodule

// File: rtl/pix_bit_encoder.sv
module pix_bit_encoder
    import pix_pkg::*;
#(
    parameter int T0H_CYC = 94,
    parameter int T1H_CYC = 212
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic val,
    output logic dout
);
    localparam int CW = $clog2(T1H_CYC + 1);

    enc_state_e    state;
    logic [CW-1:0] cnt;
    logic [CW-1:0] width;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ENC_IDLE;
            cnt   <= '0;
            width <= '0;
        end else if (start) begin
            state <= ENC_HIGH;
            cnt   <= CW'(1);
            width <= CW'(pulse_width(val, T0H_CYC, T1H_CYC));
        end else if (state == ENC_HIGH) begin
            if (cnt == width) state <= ENC_IDLE;
            else              cnt   <= cnt + CW'(1);
        end
    end

    assign dout = (state == ENC_HIGH);

    a_r3_start_goes_high: assert property (@(posedge clk) disable iff (rst)
        start |=> dout);
endmodule

// File: rtl/pix_pwm.sv
module pix_pwm
    import pix_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  pix_word_t        duty,
    output logic [PIX_NCH-1:0] pwm_o
);
    logic [PIX_DW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) phase <= '0;
        else     phase <= phase + PIX_DW'(1);
    end

    for (genvar i = 0; i < PIX_NCH; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) pwm_o[i] <= 1'b0;
            else     pwm_o[i] <= (phase < duty[PIX_NCH-1-i]);
        end

        a_r8_zero_duty_off: assert property (@(posedge clk) disable iff (rst)
            ($past(duty[PIX_NCH-1-i]) == '0) |-> !pwm_o[i]);
    end
endmodule

// File: rtl/pix_node.sv
module pix_node
    import pix_pkg::*;
#(
    parameter int T0H_CYC    = 94,
    parameter int T1H_CYC    = 212,
    parameter int SAMPLE_CYC = 150,
    parameter int RESET_CYC  = 70000
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      din,
    output logic                      dout,
    output logic [PIX_NCH-1:0]        pwm_o,
    output logic [PIX_FRAME_BITS-1:0] duty_dbg
);
    localparam int FW = $clog2(PIX_FRAME_BITS + 1);

    pix_bit_t                  rx_bit;
    logic                      idle;
    logic [FW-1:0]             cap_cnt;
    logic [PIX_FRAME_BITS-1:0] hold;
    pix_word_t                 duty_q;
    logic                      fwd_start;
    logic                      full;

    pix_bit_decoder #(.SAMPLE_CYC(SAMPLE_CYC), .RESET_CYC(RESET_CYC)) u_dec (
        .clk(clk), .rst(rst), .din(din), .bit_o(rx_bit), .idle_o(idle));

    assign full      = (cap_cnt == FW'(PIX_FRAME_BITS));
    assign fwd_start = rx_bit.vld && full;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_cnt <= '0;
            hold    <= '0;
            duty_q  <= '0;
        end else if (idle) begin
            if (full) duty_q <= pix_word_t'(hold);
            cap_cnt <= '0;
        end else if (rx_bit.vld && !full) begin
            hold    <= {hold[PIX_FRAME_BITS-2:0], rx_bit.val};
            cap_cnt <= cap_cnt + FW'(1);
        end
    end

    pix_bit_encoder #(.T0H_CYC(T0H_CYC), .T1H_CYC(T1H_CYC)) u_enc (
        .clk(clk), .rst(rst), .start(fwd_start), .val(rx_bit.val), .dout(dout));

    pix_pwm u_pwm (.clk(clk), .rst(rst), .duty(duty_q), .pwm_o(pwm_o));

    assign duty_dbg = duty_q;

    a_r7_duty_commit_only: assert property (@(posedge clk) disable iff (rst)
        (duty_q != $past(duty_q)) |-> $past(idle));
endmodule

// File: tb/pix_node_tb.sv
module pix_node_tb;
    localparam int BIT_CYC = 32;
    localparam int T0H = 8, T1H = 20, SMP = 14, RST_CYC = 200;

    logic        clk = 0, rst = 1, din = 0;
    logic        dout;
    logic [2:0]  pwm_o;
    logic [23:0] duty_dbg;

    int errors = 0, checks = 0;
    int exp_q[$];
    int fwd_seen = 0, fwd_sent = 0;
    int since_idle = 0;

    always #2 clk = ~clk;

    pix_node #(.T0H_CYC(T0H), .T1H_CYC(T1H), .SAMPLE_CYC(SMP), .RESET_CYC(RST_CYC)) u_dut (
        .clk(clk), .rst(rst), .din(din), .dout(dout), .pwm_o(pwm_o), .duty_dbg(duty_dbg));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: one bit with a chosen high width; pushes expected forwards (R3)
    task automatic send_bit(input logic b, input int hi);
        if (since_idle >= 24) begin
            exp_q.push_back(b ? T1H : T0H);
            fwd_sent++;
        end
        since_idle++;
        for (int i = 0; i < BIT_CYC; i++) begin
            @(negedge clk);
            din = (i < hi);
        end
    endtask

    task automatic send_byte(input logic [7:0] v, input int w0, input int w1);
        for (int i = 7; i >= 0; i--) send_bit(v[i], v[i] ? w1 : w0);
    endtask

    task automatic idle_gap();
        @(negedge clk);
        din = 0;
        repeat (RST_CYC + 20) @(negedge clk);
        since_idle = 0;
    endtask

    // Monitor: measures each dout pulse and pops the scoreboard
    int hi_len = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (dout) hi_len++;
            else if (hi_len != 0) begin
                fwd_seen++;
                if (exp_q.size() == 0) check("R4 unexpected pulse", hi_len, 0);
                else check("R3 forwarded width", hi_len, exp_q.pop_front());
                hi_len = 0;
            end
        end
    end

    task automatic check_pwm(input string req, input int ch, input int exp);
        int n = 0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            if (pwm_o[ch]) n++;
        end
        check(req, n, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R10 reset state
        check("R10 duty", duty_dbg, 0);
        check("R10 dout", dout, 0);
        check("R10 pwm", pwm_o, 0);
        rst = 0;
        idle_gap();

        // Frame with 3 pixels: own pixel then 48 forwarded bits
        send_byte(8'hA5, T0H, T1H); send_byte(8'h00, T0H, T1H); send_byte(8'hFF, T0H, T1H);
        check("R4 no pulse during capture", fwd_seen, 0);
        check("R7 duty before commit", duty_dbg, 0);
        send_byte(8'h3C, T0H, T1H); send_byte(8'h81, T0H, T1H); send_byte(8'h55, T0H, T1H);
        send_byte(8'hF0, T0H, T1H); send_byte(8'h0F, T0H, T1H); send_byte(8'h99, T0H, T1H);
        idle_gap();
        check("R2 R5 committed word", duty_dbg, 24'hA500FF);
        check("R3 all forwarded", fwd_seen, fwd_sent);
        check("R3 queue drained", exp_q.size(), 0);
        check_pwm("R9 ch0 duty 0xA5", 0, 165);
        check_pwm("R8 ch1 duty 0", 1, 0);
        check_pwm("R9 ch2 duty 255", 2, 255);

        // R6 partial frame is dropped
        send_byte(8'h12, T0H, T1H); send_bit(1'b1, T1H); send_bit(1'b0, T0H);
        idle_gap();
        check("R6 duty unchanged", duty_dbg, 24'hA500FF);

        // R1 widths near the sample point; R6 fresh capture; exactly 24 bits
        send_byte(8'h3C, 11, 17); send_byte(8'hC3, 11, 17); send_byte(8'h01, 11, 17);
        idle_gap();
        check("R1 R6 new word", duty_dbg, 24'h3CC301);
        check("R4 no forwards for 24-bit frame", fwd_seen, fwd_sent);
        check_pwm("R2 R9 ch0 duty 0x3C", 0, 60);
        check_pwm("R2 R9 ch1 duty 0xC3", 1, 195);
        check_pwm("R2 R9 ch2 duty 0x01", 2, 1);

        // R1 short zero and long one extremes, with a forwarded tail
        send_byte(8'h80, 3, 30); send_byte(8'h7F, 3, 30); send_byte(8'hAA, 3, 30);
        send_byte(8'h6B, 3, 30);
        idle_gap();
        check("R1 extreme widths", duty_dbg, 24'h807FAA);
        check("R3 tail forwarded", fwd_seen, fwd_sent);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule